// File: doc/BRIEF.md
# Four-Register Single-Cycle Datapath

This block is the execute stage of a small processor. It has four registers, a function unit that joins an arithmetic/logic unit and a one-bit shifter, and the multiplexers that connect them. One control word, applied for one clock, performs one microoperation. The word picks two source registers, an optional constant operand, the ALU function, the shift direction, the result source and the destination register. The result is written back on the next rising clock edge.

Both operand buses are driven out of the block. Bus A serves as the outgoing address and bus B as the outgoing data. External data can be written into any register through the write-back multiplexer, which is how the registers get their first values. Four status flags come out combinationally: overflow, carry, negative and zero. Sequencing of the control words is left to whatever drives the control inputs.

Top module: `rf_datapath`

## Requirements
- R1: While `rst_n` is low, all four registers are cleared to zero, and they read back as zero on both buses after reset.
- R2: On a rising edge with `ld_en` = 1, only the register numbered `dst_sel` takes the write-back value. The other three registers keep their contents.
- R3: Reads are combinational. `addr_out` shows the register picked by `a_sel`. `data_out` shows the register picked by `b_sel` when `mb_sel` = 0, and shows `const_in` when `mb_sel` = 1.
- R4: `g_sel` = {S2,S1,S0,Cin}. When S2 = 0 the ALU computes A + Y + Cin, where Y is chosen by S1S0: 00 gives zero, 01 gives B, 10 gives ~B and 11 gives all ones. `c_flag` is the carry out of the top bit.
- R5: When S2 = 1, S1S0 selects the logic function: 00 is A AND B, 01 is A OR B, 10 is A XOR B and 11 is NOT A. Cin has no effect, and `c_flag` and `v_flag` are both 0.
- R6: For the arithmetic codes, `v_flag` is 1 exactly when the two's-complement sum A + Y + Cin does not fit in WIDTH bits.
- R7: The shifter works on bus B, with `h_sel` selecting the operation. 00 and 11 pass bus B through. 01 shifts right and fills the top bit from `fill_r`. 10 shifts left and fills the bottom bit from `fill_l`.
- R8: `mf_sel` = 0 selects the ALU as the function output and 1 selects the shifter. `md_sel` = 0 writes the function output back and 1 writes `data_in`.
- R9: `n_flag` is the top bit of the function output. `z_flag` is 1 exactly when the function output is zero.
- R10: With `ld_en` = 0, no register changes, whatever the destination and the data.
- R11: R0 ← R1 + R2 finishes in one clock with `a_sel`=01, `b_sel`=10, `mb_sel`=0, `g_sel`=0010, `mf_sel`=0, `md_sel`=0, `dst_sel`=00 and `ld_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write enable for the register file |
| dst_sel | input | 2 | Destination register number |
| a_sel | input | 2 | Register that drives bus A |
| b_sel | input | 2 | Register that drives bus B |
| mb_sel | input | 1 | Bus B source: 0 register, 1 constant |
| const_in | input | WIDTH | Constant operand |
| g_sel | input | 4 | ALU function {S2,S1,S0,Cin} |
| h_sel | input | 2 | Shifter operation |
| fill_r | input | 1 | Bit shifted in at the top on a right shift |
| fill_l | input | 1 | Bit shifted in at the bottom on a left shift |
| mf_sel | input | 1 | Function output: 0 ALU, 1 shifter |
| md_sel | input | 1 | Write-back value: 0 function output, 1 data_in |
| data_in | input | WIDTH | External write-back data |
| addr_out | output | WIDTH | Bus A |
| data_out | output | WIDTH | Bus B |
| v_flag | output | 1 | Overflow |
| c_flag | output | 1 | Carry |
| n_flag | output | 1 | Negative |
| z_flag | output | 1 | Zero |

## Verification
A wrong register value shows up on `addr_out` or `data_out` as soon as that register is selected, in the same cycle and with no clock needed. A bad write is therefore visible one edge after the write. An ALU or shifter error shows up at once in the flags. It also shows up in the written register, one clock later, when that register is read back on bus A. A decoder fault that touches a neighbouring register, or a write that ignores the enable, only appears when that neighbour is read back. For this reason the bench reads every register after writes and after writes that should have been blocked.

// File: rtl/dp_pkg.sv
`timescale 1ns/1ps
package dp_pkg;
  localparam int GSEL_W = 4;
  localparam int HSEL_W = 2;

  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_HOLD  = 2'b11
  } shift_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOT = 2'b11
  } logic_op_e;
endpackage

// File: rtl/dp_regfile.sv
`timescale 1ns/1ps
module dp_regfile #(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] dst_sel,
  input  logic [WIDTH-1:0] wdata,
  input  logic [SEL_W-1:0] rd_a_sel,
  input  logic [SEL_W-1:0] rd_b_sel,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_b
);
  logic [NREGS-1:0][WIDTH-1:0] regs;
  logic [NREGS-1:0]            load_vec;

  // destination decoder and per-register storage
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    assign load_vec[i] = ld_en && (dst_sel == SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           regs[i] <= '0;
      else if (load_vec[i]) regs[i] <= wdata;
    end
  end

  assign rd_a = regs[rd_a_sel];
  assign rd_b = regs[rd_b_sel];

  p_onehot_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> $countones(load_vec) == 1);
  p_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |-> load_vec == '0);
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> regs[$past(dst_sel)] == $past(wdata));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> regs == $past(regs));
endmodule

// File: rtl/dp_alu.sv
`timescale 1ns/1ps
module dp_alu
  import dp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  opa,
  input  logic [WIDTH-1:0]  opb,
  input  logic [GSEL_W-1:0] g_sel,
  output logic [WIDTH-1:0]  res,
  output logic              carry,
  output logic              ovf
);
  // second adder operand, picked by S1:S0
  function automatic logic [WIDTH-1:0] pick_y(input logic [1:0] s, input logic [WIDTH-1:0] b);
    case (s)
      2'b00:   return '0;
      2'b01:   return b;
      2'b10:   return ~b;
      default: return '1;
    endcase
  endfunction

  // sum one bit wider than the operands, so the top bit is the carry
  function automatic logic [WIDTH:0] add_wide(input logic [WIDTH-1:0] a,
                                              input logic [WIDTH-1:0] y,
                                              input logic cin);
    return {1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  endfunction

  function automatic logic [WIDTH-1:0] logic_fn(input logic_op_e op,
                                                input logic [WIDTH-1:0] a,
                                                input logic [WIDTH-1:0] b);
    case (op)
      LG_AND:  return a & b;
      LG_OR:   return a | b;
      LG_XOR:  return a ^ b;
      default: return ~a;
    endcase
  endfunction

  logic [WIDTH-1:0] y_opnd;
  logic [WIDTH:0]   sum;
  logic             arith_ovf;

  always_comb begin
    y_opnd    = pick_y(g_sel[2:1], opb);
    sum       = add_wide(opa, y_opnd, g_sel[0]);
    arith_ovf = (opa[WIDTH-1] == y_opnd[WIDTH-1]) && (sum[WIDTH-1] != opa[WIDTH-1]);
    if (g_sel[3]) begin
      res   = logic_fn(logic_op_e'(g_sel[2:1]), opa, opb);
      carry = 1'b0;
      ovf   = 1'b0;
    end else begin
      res   = sum[WIDTH-1:0];
      carry = sum[WIDTH];
      ovf   = arith_ovf;
    end
  end
endmodule

// File: rtl/dp_shifter.sv
`timescale 1ns/1ps
module dp_shifter
  import dp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  din,
  input  logic [HSEL_W-1:0] h_sel,
  input  logic              fill_r,
  input  logic              fill_l,
  output logic [WIDTH-1:0]  dout
);
  function automatic logic [WIDTH-1:0] shift_word(input shift_op_e op,
                                                  input logic [WIDTH-1:0] d,
                                                  input logic fr,
                                                  input logic fl);
    case (op)
      SH_RIGHT: return {fr, d[WIDTH-1:1]};
      SH_LEFT:  return {d[WIDTH-2:0], fl};
      default:  return d;
    endcase
  endfunction

  assign dout = shift_word(shift_op_e'(h_sel), din, fill_r, fill_l);
endmodule

// File: rtl/rf_datapath.sv
`timescale 1ns/1ps
module rf_datapath
  import dp_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  dst_sel,
  input  logic [SEL_W-1:0]  a_sel,
  input  logic [SEL_W-1:0]  b_sel,
  input  logic              mb_sel,
  input  logic [WIDTH-1:0]  const_in,
  input  logic [GSEL_W-1:0] g_sel,
  input  logic [HSEL_W-1:0] h_sel,
  input  logic              fill_r,
  input  logic              fill_l,
  input  logic              mf_sel,
  input  logic              md_sel,
  input  logic [WIDTH-1:0]  data_in,
  output logic [WIDTH-1:0]  addr_out,
  output logic [WIDTH-1:0]  data_out,
  output logic              v_flag,
  output logic              c_flag,
  output logic              n_flag,
  output logic              z_flag
);
  // named internal nets used by the assertions below
  logic [WIDTH-1:0] bus_a, reg_b, bus_b;
  logic [WIDTH-1:0] alu_res, sh_res, fu_out, wb_data;
  logic             alu_c, alu_v;

  dp_regfile #(.WIDTH(WIDTH), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .dst_sel(dst_sel),
    .wdata(wb_data), .rd_a_sel(a_sel), .rd_b_sel(b_sel),
    .rd_a(bus_a), .rd_b(reg_b)
  );

  assign bus_b = mb_sel ? const_in : reg_b;

  dp_alu #(.WIDTH(WIDTH)) u_alu (
    .opa(bus_a), .opb(bus_b), .g_sel(g_sel),
    .res(alu_res), .carry(alu_c), .ovf(alu_v)
  );

  dp_shifter #(.WIDTH(WIDTH)) u_sh (
    .din(bus_b), .h_sel(h_sel), .fill_r(fill_r), .fill_l(fill_l), .dout(sh_res)
  );

  assign fu_out   = mf_sel ? sh_res : alu_res;
  assign wb_data  = md_sel ? data_in : fu_out;

  assign addr_out = bus_a;
  assign data_out = bus_b;
  assign v_flag   = alu_v;
  assign c_flag   = alu_c;
  assign n_flag   = fu_out[WIDTH-1];
  assign z_flag   = (fu_out == '0);

  p_const_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mb_sel |-> data_out == const_in);
  p_logic_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    g_sel[3] |-> !c_flag && !v_flag);
  p_shr_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel == SH_RIGHT) |-> sh_res[WIDTH-1] == fill_r);
  p_shl_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel == SH_LEFT) |-> sh_res[0] == fill_l);
  p_ext_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (md_sel && ld_en) |=> $past(data_in) == $past(wb_data));
  p_zero_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    z_flag |-> !n_flag);
endmodule

// File: tb/rf_datapath_bench.sv
`timescale 1ns/1ps
module rf_datapath_bench;
  localparam int W = 8;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 0, mb_sel = 0, fill_r = 0, fill_l = 0, mf_sel = 0, md_sel = 0;
  logic [1:0] dst_sel = 0, a_sel = 0, b_sel = 0, h_sel = 0;
  logic [3:0] g_sel = 0;
  logic [W-1:0] const_in = 0, data_in = 0;
  logic [W-1:0] addr_out, data_out;
  logic v_flag, c_flag, n_flag, z_flag;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rf_datapath #(.WIDTH(W), .NREGS(4)) u_rf_datapath (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .dst_sel(dst_sel),
    .a_sel(a_sel), .b_sel(b_sel), .mb_sel(mb_sel), .const_in(const_in),
    .g_sel(g_sel), .h_sel(h_sel), .fill_r(fill_r), .fill_l(fill_l),
    .mf_sel(mf_sel), .md_sel(md_sel), .data_in(data_in),
    .addr_out(addr_out), .data_out(data_out),
    .v_flag(v_flag), .c_flag(c_flag), .n_flag(n_flag), .z_flag(z_flag)
  );

  // vector layout: g[24:21] h[20:19] mf[18] fill_r[17] fill_l[16] a[15:8] b[7:0]
  localparam logic [24:0] VEC [NV] = '{
    {4'b0010, 2'b00, 1'b0, 1'b0, 1'b0, 8'h7F, 8'h01},
    {4'b0010, 2'b00, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h01},
    {4'b0000, 2'b00, 1'b0, 1'b0, 1'b0, 8'h9C, 8'h33},
    {4'b0001, 2'b00, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h10},
    {4'b0011, 2'b00, 1'b0, 1'b0, 1'b0, 8'h40, 8'h3F},
    {4'b0100, 2'b00, 1'b0, 1'b0, 1'b0, 8'h20, 8'h05},
    {4'b0101, 2'b00, 1'b0, 1'b0, 1'b0, 8'h80, 8'h01},
    {4'b0110, 2'b00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h77},
    {4'b0111, 2'b00, 1'b0, 1'b0, 1'b0, 8'h5A, 8'hC3},
    {4'b1000, 2'b00, 1'b0, 1'b0, 1'b0, 8'hF0, 8'h3C},
    {4'b1010, 2'b00, 1'b0, 1'b0, 1'b0, 8'hA0, 8'h05},
    {4'b1100, 2'b00, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF},
    {4'b1110, 2'b00, 1'b0, 1'b0, 1'b0, 8'h0F, 8'h00},
    {4'b1011, 2'b00, 1'b0, 1'b0, 1'b0, 8'h81, 8'h18},
    {4'b0010, 2'b01, 1'b1, 1'b1, 1'b0, 8'h11, 8'h02},
    {4'b0000, 2'b10, 1'b1, 1'b0, 1'b1, 8'h22, 8'h81},
    {4'b0101, 2'b00, 1'b1, 1'b1, 1'b1, 8'h01, 8'hC4},
    {4'b1110, 2'b11, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // independent reference written with integer arithmetic
  task automatic model(input logic [3:0] g, input logic [1:0] h, input logic mf,
                       input logic fr, input logic fl, input logic [7:0] a, input logic [7:0] b,
                       output logic [7:0] f, output logic c, output logic v);
    int y, s, sa, sy, ss;
    logic [7:0] alu, sh;
    case (g[2:1])
      2'd0: y = 0;
      2'd1: y = int'(b);
      2'd2: y = 255 - int'(b);
      default: y = 255;
    endcase
    s  = int'(a) + y + int'(g[0]);
    sa = (a > 8'd127) ? int'(a) - 256 : int'(a);
    sy = (y > 127) ? y - 256 : y;
    ss = sa + sy + int'(g[0]);
    alu = s[7:0];
    c = (s > 255);
    v = (ss > 127) || (ss < -128);
    if (g[3]) begin
      c = 0; v = 0;
      case (g[2:1])
        2'd0: alu = a & b;
        2'd1: alu = a | b;
        2'd2: alu = a ^ b;
        default: alu = ~a;
      endcase
    end
    if (h == 2'b01)      sh = {fr, b[7:1]};
    else if (h == 2'b10) sh = {b[6:0], fl};
    else                 sh = b;
    f = mf ? sh : alu;
  endtask

  task automatic idle_ctrl();
    ld_en = 0; mb_sel = 0; mf_sel = 0; md_sel = 0; g_sel = 0; h_sel = 0;
    fill_r = 0; fill_l = 0;
  endtask

  task automatic load_reg(input logic [1:0] idx, input logic [7:0] val);
    @(negedge clk);
    idle_ctrl();
    ld_en = 1; dst_sel = idx; md_sel = 1; data_in = val;
    @(negedge clk);
    ld_en = 0; md_sel = 0;
  endtask

  task automatic read_reg(input logic [1:0] idx, output logic [7:0] val);
    a_sel = idx; mb_sel = 0;
    #1 val = addr_out;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] rv, ef;
    logic ec, ev;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: every register reads zero after reset, on both buses
    for (int i = 0; i < 4; i++) begin
      a_sel = 2'(i); b_sel = 2'(i); mb_sel = 0;
      #1;
      check("R1 bus A", int'(addr_out), 0);
      check("R1 bus B", int'(data_out), 0);
    end

    // R2 / R8: external writes into each register
    load_reg(2'd0, 8'h11); load_reg(2'd1, 8'h22);
    load_reg(2'd2, 8'h33); load_reg(2'd3, 8'h44);
    for (int i = 0; i < 4; i++) begin
      read_reg(2'(i), rv);
      check("R2 write each register", int'(rv), 17 * (i + 1));
    end
    // R2: rewrite R1 only; neighbours keep their values
    load_reg(2'd1, 8'hA5);
    read_reg(2'd0, rv); check("R2 neighbour R0 kept", int'(rv), 'h11);
    read_reg(2'd1, rv); check("R2 target R1", int'(rv), 'hA5);
    read_reg(2'd2, rv); check("R2 neighbour R2 kept", int'(rv), 'h33);

    // R10: write disabled -> register unchanged
    @(negedge clk);
    idle_ctrl(); dst_sel = 2'd2; md_sel = 1; data_in = 8'hEE; ld_en = 0;
    @(negedge clk);
    md_sel = 0;
    read_reg(2'd2, rv); check("R10 no write when disabled", int'(rv), 'h33);

    // R3: bus B register read, then the constant
    b_sel = 2'd3; mb_sel = 0; #1;
    check("R3 bus B register", int'(data_out), 'h44);
    mb_sel = 1; const_in = 8'h5A; #1;
    check("R3 constant on bus B", int'(data_out), 'h5A);
    mb_sel = 0;

    // R8: md_sel=1 writes data_in even when the ALU result differs
    @(negedge clk);
    idle_ctrl(); a_sel = 2'd0; b_sel = 2'd0; g_sel = 4'b0001;
    md_sel = 1; data_in = 8'h3C; dst_sel = 2'd3; ld_en = 1;
    @(negedge clk);
    idle_ctrl();
    read_reg(2'd3, rv); check("R8 external data selected", int'(rv), 'h3C);

    // table walk: R4 R5 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      load_reg(2'd1, VEC[k][15:8]);
      load_reg(2'd2, VEC[k][7:0]);
      model(VEC[k][24:21], VEC[k][20:19], VEC[k][18], VEC[k][17], VEC[k][16],
            VEC[k][15:8], VEC[k][7:0], ef, ec, ev);
      tag = VEC[k][18] ? "R7 shifter" : (VEC[k][24] ? "R5 logic" : "R4 arithmetic");
      @(negedge clk);
      a_sel = 2'd1; b_sel = 2'd2; mb_sel = 0; md_sel = 0;
      g_sel = VEC[k][24:21]; h_sel = VEC[k][20:19]; mf_sel = VEC[k][18];
      fill_r = VEC[k][17]; fill_l = VEC[k][16]; dst_sel = 2'd3; ld_en = 1;
      #1;
      check({tag, " carry"}, int'(c_flag), int'(ec));
      check("R6 overflow", int'(v_flag), int'(ev));
      check("R9 negative", int'(n_flag), int'(ef[7]));
      check("R9 zero", int'(z_flag), int'(ef == 8'h00));
      @(negedge clk);
      idle_ctrl();
      read_reg(2'd3, rv);
      check({tag, " result (R8 write-back)"}, int'(rv), int'(ef));
    end

    // R11: R0 <- R1 + R2 in one clock with the exact control word
    load_reg(2'd1, 8'h29);
    load_reg(2'd2, 8'h16);
    @(negedge clk);
    idle_ctrl();
    a_sel = 2'b01; b_sel = 2'b10; mb_sel = 0; g_sel = 4'b0010;
    mf_sel = 0; md_sel = 0; dst_sel = 2'b00; ld_en = 1;
    @(negedge clk);
    idle_ctrl();
    read_reg(2'd0, rv); check("R11 single-cycle add", int'(rv), 'h3F);
    read_reg(2'd3, rv); check("R11 R3 untouched", int'(rv), int'(ef));

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule